// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Register File

This block is the control core of one DMA channel. A host processor programs a start address, a transfer count and an operand size through a small register file, then sets a start bit. While the channel is busy, the peripheral-side handshake reports each finished transfer with a one-cycle `xfer_done` strobe. On each strobe the core moves the memory address forward by the operand width and lowers the remaining count by one.

When the count runs out, the channel goes idle, raises a done flag and, if enabled, an interrupt. The interrupt stays up until software clears the flag. Software can abort a running channel. Illegal set-up, and attempts to reprogram a busy channel, are recorded as coded errors. During an interrupt-acknowledge cycle the core drives a programmable vector, which resets to 0x0F.

Top module: `dma_chan_core`

## Requirements
- R1: After reset the address and count read 0, the operation, control, status and error registers read 0, the vector register reads 0x0F, and `irq` and `xfer_busy` are low.
- R2: Register selects on `cpu_sel` are: 0 address, 1 count (16 bits), 2 operation, 3 control, 4 status, 5 error code, 6 vector. Unused bits read as zero.
- R3: Each `xfer_done` strobe while busy adds a step to the address. The step is 1, 2 or 4 for size codes 00, 01 and 10 in operation bits 5:4.
- R4: Each `xfer_done` strobe while busy lowers the count by one. A strobe while idle changes neither address nor count.
- R5: A control write that sets bit 7 while the stored bit 7 is 0 and the channel is idle makes `xfer_busy` high from the next cycle. Writing bit 7 again while it is already set has no effect.
- R6: When the count steps from 1 to 0, the channel goes idle and status bit 7 (done) is set. `irq` rises if control bit 3 is set. Both hold until software writes 1 to status bit 7.
- R7: A control write with bit 4 set while busy returns the channel to idle at once. It stops any further advances, sets error code 3 and sets status bit 6. The same write while idle has no effect.
- R8: While busy, writes to the address, count or operation registers are discarded. They set error code 1 and status bit 6.
- R9: A start with size code 11 or a zero count does not make the channel busy. It sets error code 2 and status bit 6.
- R10: `vec_out` carries the vector register while `iack` is high and 0 otherwise. The vector register can be rewritten by software.
- R11: Writing 1 to status bit 6 clears the error bit and resets the error code to 0.
- R12: `xfer_to_mem` follows operation bit 7 (1 means peripheral to memory), and `xfer_size` follows bits 5:4. Status bit 3 mirrors `xfer_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 3 | Register select for reads and writes |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for the selected register |
| xfer_done | input | 1 | One-cycle strobe marking a completed transfer |
| iack | input | 1 | Interrupt-acknowledge cycle in progress |
| mem_addr | output | 32 | Current memory address |
| xfer_busy | output | 1 | Channel active |
| xfer_to_mem | output | 1 | Direction: peripheral to memory when high |
| xfer_size | output | 2 | Operand size code |
| irq | output | 1 | Completion interrupt |
| vec_out | output | 8 | Interrupt vector during acknowledge |

## Verification
The hardest states to reach from the ports are the ones where software acts on a channel that is in the middle of a run. Examples are an abort after some strobes, a reprogram attempt while busy, and a repeated start bit. In each case the bench first starts a run with a count larger than the strobes it sends, so the channel is still busy. It then makes the write and reads back address, count, status and error code through the register file. A table run drives complete transfers at every legal size, including a run where the address wraps past the top of the space.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_CNT  = 3'd1,
    SEL_OP   = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4,
    SEL_ERR  = 3'd5,
    SEL_VEC  = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_TIMING = 2'd1,
    ERR_CONFIG = 2'd2,
    ERR_ABORT  = 2'd3
  } err_code_e;

  localparam int OP_DIR_BIT   = 7;
  localparam int OP_SZ_LO     = 4;
  localparam int CTL_GO_BIT   = 7;
  localparam int CTL_STOP_BIT = 4;
  localparam int CTL_IEN_BIT  = 3;
  localparam int ST_DONE_BIT  = 7;
  localparam int ST_ERR_BIT   = 6;
  localparam int ST_ACT_BIT   = 3;
  localparam logic [7:0] VEC_RESET = 8'h0F;

  // address increment for an operand size code; 0 for the reserved code
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_cnt.sv
module dma_chan_cnt
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_addr,
  input  logic          load_cnt,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          advance,
  input  logic [1:0]    sz,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          cnt_last,
  output logic          cnt_zero
);

  localparam int PADW = AW - 3;

  logic [AW-1:0] step_ext;
  assign step_ext = {{PADW{1'b0}}, size_step(sz)};
  assign cnt_last = (cnt == CW'(1));
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (load_addr)    addr <= addr_in;
      else if (advance) addr <= addr + step_ext;
      if (load_cnt)     cnt  <= cnt_in;
      else if (advance) cnt  <= cnt - CW'(1);
    end
  end

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cnt == $past(cnt) - CW'(1))); // R4

  AST_NO_MOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load_addr) |=> $stable(addr)); // R4

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [2:0] cpu_sel,
  input  logic [7:0] wbyte,
  input  logic       xfer_done,
  input  logic       cnt_last,
  input  logic       cnt_zero,
  output logic       active,
  output logic [7:0] op_q,
  output logic [7:0] ctl_q,
  output logic [7:0] vec_q,
  output logic       done_f,
  output logic       err_f,
  output err_code_e  err_code,
  output logic       load_addr,
  output logic       load_cnt,
  output logic       advance,
  output logic       irq
);

  // named internal events
  logic wr_addr, wr_cnt, wr_op, wr_ctl, wr_stat, wr_vec;
  logic start_ev, abort_ev, cfg_ev, go_ev, timing_ev, finish_ev;
  logic clr_done, clr_err, err_set;
  err_code_e code_new;

  assign wr_addr = cpu_wr && (cpu_sel == SEL_ADDR);
  assign wr_cnt  = cpu_wr && (cpu_sel == SEL_CNT);
  assign wr_op   = cpu_wr && (cpu_sel == SEL_OP);
  assign wr_ctl  = cpu_wr && (cpu_sel == SEL_CTRL);
  assign wr_stat = cpu_wr && (cpu_sel == SEL_STAT);
  assign wr_vec  = cpu_wr && (cpu_sel == SEL_VEC);

  assign start_ev  = wr_ctl && wbyte[CTL_GO_BIT] && !ctl_q[CTL_GO_BIT] && !active;
  assign abort_ev  = wr_ctl && wbyte[CTL_STOP_BIT] && active;
  assign cfg_ev    = start_ev && ((op_q[OP_SZ_LO+1:OP_SZ_LO] == 2'b11) || cnt_zero);
  assign go_ev     = start_ev && !cfg_ev;
  assign timing_ev = active && (wr_addr || wr_cnt || wr_op);
  assign advance   = active && xfer_done && !abort_ev;
  assign finish_ev = advance && cnt_last;
  assign load_addr = wr_addr && !active;
  assign load_cnt  = wr_cnt && !active;
  assign clr_done  = wr_stat && wbyte[ST_DONE_BIT];
  assign clr_err   = wr_stat && wbyte[ST_ERR_BIT];
  assign err_set   = abort_ev || cfg_ev || timing_ev;
  assign irq       = done_f && ctl_q[CTL_IEN_BIT];

  always_comb begin
    if (abort_ev)    code_new = ERR_ABORT;
    else if (cfg_ev) code_new = ERR_CONFIG;
    else             code_new = ERR_TIMING;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      op_q     <= '0;
      ctl_q    <= '0;
      vec_q    <= VEC_RESET;
      done_f   <= 1'b0;
      err_f    <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      if (abort_ev || finish_ev) active <= 1'b0;
      else if (go_ev)            active <= 1'b1;

      if (wr_op && !active)
        op_q <= {wbyte[OP_DIR_BIT], 1'b0, wbyte[OP_SZ_LO+1:OP_SZ_LO], 4'b0};
      if (wr_ctl)
        ctl_q <= {wbyte[CTL_GO_BIT], 3'b0, wbyte[CTL_IEN_BIT], 3'b0};
      if (wr_vec) vec_q <= wbyte;

      if (finish_ev)     done_f <= 1'b1;
      else if (clr_done) done_f <= 1'b0;

      if (err_set) begin
        err_f    <= 1'b1;
        err_code <= code_new;
      end else if (clr_err) begin
        err_f    <= 1'b0;
        err_code <= ERR_NONE;
      end
    end
  end

  AST_GO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    go_ev |=> active); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !clr_done) |=> done_f); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!active && err_code == ERR_ABORT)); // R7

  AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && active) |=> $stable(op_q)); // R8

  AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ev |=> (!active && err_f)); // R9

endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cpu_sel,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          xfer_done,
  input  logic          iack,
  output logic [AW-1:0] mem_addr,
  output logic          xfer_busy,
  output logic          xfer_to_mem,
  output logic [1:0]    xfer_size,
  output logic          irq,
  output logic [7:0]    vec_out
);

  logic          active, done_f, err_f;
  logic [7:0]    op_q, ctl_q, vec_q;
  err_code_e     err_code;
  logic          load_addr, load_cnt, advance, cnt_last, cnt_zero;
  logic [CW-1:0] cnt;
  logic [7:0]    stat_byte;

  dma_chan_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_sel   (cpu_sel),
    .wbyte     (cpu_wdata[7:0]),
    .xfer_done (xfer_done),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero),
    .active    (active),
    .op_q      (op_q),
    .ctl_q     (ctl_q),
    .vec_q     (vec_q),
    .done_f    (done_f),
    .err_f     (err_f),
    .err_code  (err_code),
    .load_addr (load_addr),
    .load_cnt  (load_cnt),
    .advance   (advance),
    .irq       (irq)
  );

  dma_chan_cnt #(.AW(AW), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (load_addr),
    .load_cnt  (load_cnt),
    .addr_in   (cpu_wdata[AW-1:0]),
    .cnt_in    (cpu_wdata[CW-1:0]),
    .advance   (advance),
    .sz        (op_q[OP_SZ_LO+1:OP_SZ_LO]),
    .addr      (mem_addr),
    .cnt       (cnt),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero)
  );

  assign xfer_busy   = active;
  assign xfer_to_mem = op_q[OP_DIR_BIT];
  assign xfer_size   = op_q[OP_SZ_LO+1:OP_SZ_LO];
  assign vec_out     = iack ? vec_q : 8'h00;

  always_comb begin
    stat_byte = '0;
    stat_byte[ST_DONE_BIT] = done_f;
    stat_byte[ST_ERR_BIT]  = err_f;
    stat_byte[ST_ACT_BIT]  = active;
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_sel)
      SEL_ADDR: cpu_rdata = DW'(mem_addr);
      SEL_CNT:  cpu_rdata = DW'(cnt);
      SEL_OP:   cpu_rdata = DW'(op_q);
      SEL_CTRL: cpu_rdata = DW'(ctl_q);
      SEL_STAT: cpu_rdata = DW'(stat_byte);
      SEL_ERR:  cpu_rdata = DW'(err_code);
      SEL_VEC:  cpu_rdata = DW'(vec_q);
      default:  cpu_rdata = '0;
    endcase
  end

  AST_FINISH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xfer_done && cnt_last && ctl_q[CTL_IEN_BIT] && !(cpu_wr && cpu_sel == SEL_CTRL))
      |=> (irq && !xfer_busy)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (mem_addr == $past(mem_addr) + AW'(size_step($past(xfer_size))))); // R3

endmodule

// File: tb/test_dma_chan_core.sv
module test_dma_chan_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu_sel = '0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        xfer_done = 1'b0;
  logic        iack = 1'b0;
  logic [31:0] mem_addr;
  logic        xfer_busy, xfer_to_mem, irq;
  logic [1:0]  xfer_size;
  logic [7:0]  vec_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_core i_dma_chan_core (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_done(xfer_done),
    .iack(iack), .mem_addr(mem_addr), .xfer_busy(xfer_busy),
    .xfer_to_mem(xfer_to_mem), .xfer_size(xfer_size), .irq(irq),
    .vec_out(vec_out)
  );

  typedef struct packed {
    logic        dir;
    logic [1:0]  sz;
    logic [31:0] a0;
    logic [15:0] n;
    logic        ien;
    logic [31:0] a_exp;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{1'b1, 2'b00, 32'h0000_0100, 16'd3, 1'b1, 32'h0000_0103},
    '{1'b0, 2'b01, 32'h0000_0200, 16'd4, 1'b0, 32'h0000_0208},
    '{1'b1, 2'b10, 32'h0000_1000, 16'd2, 1'b1, 32'h0000_1008},
    '{1'b0, 2'b10, 32'hFFFF_FFFC, 16'd2, 1'b0, 32'h0000_0004}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    cpu_sel = s;
    #1 v = cpu_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
    end
  endtask

  task automatic setup(input logic [31:0] a, input logic [15:0] n, input logic [7:0] op);
    wr(3'd0, a); wr(3'd1, {16'h0, n}); wr(3'd2, {24'h0, op});
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 addr", v, 0);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd5, v); chk("R1 err", v, 0);
    rd(3'd6, v); chk("R1 vector", v, 32'h0F);
    chk("R1 irq/busy", {irq, xfer_busy}, 0);

    // R3 R4 R6 R12 table of complete runs
    for (int k = 0; k < 4; k++) begin
      setup(TBL[k].a0, TBL[k].n, {TBL[k].dir, 1'b0, TBL[k].sz, 4'b0});
      chk("R12 dir", xfer_to_mem, TBL[k].dir);
      chk("R12 size", xfer_size, TBL[k].sz);
      wr(3'd3, {24'h0, 8'h80 | (TBL[k].ien ? 8'h08 : 8'h00)});
      chk("R5 busy after start", xfer_busy, 1);
      rd(3'd4, v); chk("R12 status active", v, 32'h08);
      pulse(TBL[k].n);
      chk("R3 final addr", mem_addr, TBL[k].a_exp);
      rd(3'd1, v); chk("R4 count zero", v, 0);
      chk("R6 idle", xfer_busy, 0);
      rd(3'd4, v); chk("R6 done bit", v, 32'h80);
      chk("R6 irq", irq, TBL[k].ien);
      repeat (3) @(negedge clk);
      chk("R6 irq held", irq, TBL[k].ien);
      wr(3'd4, 32'h80);
      chk("R6 irq cleared", irq, 0);
      rd(3'd4, v); chk("R6 done cleared", v, 0);
      wr(3'd3, 32'h0);
    end

    // R4 strobe while idle
    v = mem_addr;
    pulse(2);
    chk("R4 idle addr", mem_addr, v);

    // R5 repeated start, R7 abort mid-run
    setup(32'h40, 16'd5, 8'h00);
    wr(3'd3, 32'h80);
    pulse(2);
    wr(3'd3, 32'h80);
    rd(3'd5, v); chk("R5 repeat start no error", v, 0);
    rd(3'd1, v); chk("R5 count unchanged", v, 3);
    wr(3'd3, 32'h90);
    chk("R7 idle", xfer_busy, 0);
    rd(3'd5, v); chk("R7 code", v, 3);
    rd(3'd4, v); chk("R7 status err", v, 32'h40);
    pulse(1);
    rd(3'd1, v); chk("R7 no advance", v, 3);
    chk("R7 addr held", mem_addr, 32'h42);

    // R11 clear error
    wr(3'd4, 32'h40);
    rd(3'd5, v); chk("R11 code clear", v, 0);
    rd(3'd4, v); chk("R11 status clear", v, 0);

    // R7 abort while idle
    wr(3'd3, 32'h10);
    rd(3'd5, v); chk("R7 idle abort no effect", v, 0);
    wr(3'd3, 32'h0);

    // R8 writes while busy
    setup(32'h500, 16'd4, 8'h10);
    wr(3'd3, 32'h80);
    wr(3'd0, 32'h9999);
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h80);
    rd(3'd0, v); chk("R8 addr kept", v, 32'h500);
    rd(3'd1, v); chk("R8 count kept", v, 4);
    rd(3'd2, v); chk("R8 op kept", v, 32'h10);
    rd(3'd5, v); chk("R8 code", v, 1);
    wr(3'd3, 32'h90);
    wr(3'd4, 32'h40);
    wr(3'd3, 32'h0);

    // R9 bad size and zero count
    setup(32'h0, 16'd2, 8'h30);
    wr(3'd3, 32'h80);
    chk("R9 size11 not busy", xfer_busy, 0);
    rd(3'd5, v); chk("R9 size11 code", v, 2);
    wr(3'd4, 32'h40); wr(3'd3, 32'h0);
    setup(32'h0, 16'd0, 8'h00);
    wr(3'd3, 32'h80);
    chk("R9 zero count not busy", xfer_busy, 0);
    rd(3'd4, v); chk("R9 zero count status", v, 32'h40);
    wr(3'd4, 32'h40); wr(3'd3, 32'h0);

    // R10 vector
    #1 chk("R10 no iack", vec_out, 0);
    iack = 1'b1;
    #1 chk("R10 reset vector", vec_out, 8'h0F);
    wr(3'd6, 32'hA5);
    #1 chk("R10 new vector", vec_out, 8'hA5);
    iack = 1'b0;
    #1 chk("R10 iack low", vec_out, 0);
    rd(3'd6, v); chk("R2 vector readback", v, 32'hA5);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule